// File: doc/BRIEF.md
# JTAG Pass-Through Bridge with Burst Counter

This block lets a host cable that reaches an FPGA through its internal boundary-scan primitive also drive a second, external JTAG port built from ordinary pins. The host uses two user scan chains of the primitive. The first chain holds a 2-bit mode code. The second chain does one of three things, depending on that code. It can give access to a 33-bit configuration register. It can forward its serial data to the target's TDI. Or it can forward its serial data to the target's TMS. In the two forwarding modes the bit returned to the host is the target's TDO.

The configuration register holds a transfer length and an end-of-shift flag. In transfer mode the block counts the data bits it forwards. It keeps target TMS low until the last bit of the burst. On that bit it drives TMS with the flag, so the target TAP leaves its shift state without the host touching TMS. In TMS mode the host walks the target TAP state machine directly. The target clock is the chain clock, passed through only while the second chain is shifting in one of the forwarding modes.

Top module: `jtag_passthru_bridge`

## Requirements
- R1: After reset the mode is idle (code 3), the committed configuration is all zero, and `tgt_tck`, `tgt_tms`, `tgt_tdi` and `chain_tdo` are low while no chain is selected.
- R2: With `usr1_sel` high, a capture loads the current mode into a 2-bit shift register and each shift moves `chain_tdi` in at the top, so the code goes in LSB first. The shift-out bit (bit 0) appears on `chain_tdo`. An update makes the shifted code the mode. The encoding is configuration=0, TMS=1, transfer=2 and idle=3. The mode changes on no other event.
- R3: In configuration mode, on the second chain a capture loads the committed 33-bit value into a shift register. Each shift moves `chain_tdi` in at bit 32, and bit 0 is returned on `chain_tdo`. An update commits the value. Bits 31:0 are the length and bit 32 is the end-of-shift flag. The committed value changes on no other event.
- R4: In transfer mode, while the second chain shifts, `tgt_tdi` equals `chain_tdi` in the same cycle. Otherwise `tgt_tdi` is low.
- R5: In transfer mode, counting shifted bits from 1 after the last clear, `tgt_tms` equals the flag on bit number L, where L is the committed length, and is low on every other bit. A length of 0 never raises it.
- R6: The bit counter clears on a second-chain capture and on a mode update.
- R7: In TMS mode, while the second chain shifts, `tgt_tms` equals `chain_tdi` and `tgt_tdi` is low.
- R8: `tgt_tck` follows `clk` only while the second chain is selected and shifting in TMS or transfer mode. In every other case it stays low.
- R9: `chain_tdo` returns `tgt_tdo` when the second chain is selected in TMS or transfer mode. It is low when neither chain is selected, or when the second chain is selected in idle mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chain clock from the boundary-scan primitive |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr1_sel | input | 1 | First user chain (mode) selected |
| usr2_sel | input | 1 | Second user chain (data) selected |
| chain_shift | input | 1 | Chain in shift state |
| chain_capture | input | 1 | Chain in capture state |
| chain_update | input | 1 | Chain in update state |
| chain_tdi | input | 1 | Serial data from the host |
| tgt_tdo | input | 1 | Serial data from the target device |
| chain_tdo | output | 1 | Serial data back to the host |
| tgt_tck | output | 1 | Gated clock to the target |
| tgt_tms | output | 1 | Mode select to the target |
| tgt_tdi | output | 1 | Serial data to the target |

## Verification
`tgt_tdi`, `tgt_tms`, `chain_tdo` and the gated clock are combinational from the chain inputs and the stored state, so they are due in the same cycle as the stimulus. The mode, the committed configuration and the bit counter change on the rising edge that samples an update, capture or shift, so their effect shows one cycle later. A behavioural model advances its state at every rising edge and compares all outputs 2 ns later, while the clock is still high, so the gated clock can be seen. Directed sequences drive the inputs on the falling edge and sample the serial outputs 1 ns after it, before the edge that consumes the bit.

// File: rtl/jpb_pkg.sv
package jpb_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_CFG  = 2'd0,
        MODE_TMS  = 2'd1,
        MODE_XFER = 2'd2,
        MODE_IDLE = 2'd3
    } jpb_mode_e;
endpackage

// File: rtl/jpb_mode_chain.sv
module jpb_mode_chain
    import jpb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel,
    input  logic      shift,
    input  logic      capture,
    input  logic      update,
    input  logic      tdi,
    output jpb_mode_e mode_q,
    output logic      so,
    output logic      upd
);
    typedef struct packed {
        logic [MODE_W-1:0] sr;
        jpb_mode_e         mode;
    } mode_st_t;

    mode_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sel && capture)
            s_d.sr = s_q.mode;
        else if (sel && shift)
            s_d.sr = {tdi, s_q.sr[MODE_W-1:1]};
        if (sel && update)
            s_d.mode = jpb_mode_e'(s_q.sr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sr   <= '0;
            s_q.mode <= MODE_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_q = s_q.mode;
    assign so     = s_q.sr[0];
    assign upd    = sel && update;
endmodule

// File: rtl/jpb_cfg_chain.sv
module jpb_cfg_chain #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             shift,
    input  logic             capture,
    input  logic             update,
    input  logic             tdi,
    output logic [LEN_W-1:0] len,
    output logic             flag,
    output logic             so
);
    localparam int REG_W = LEN_W + 1;

    typedef struct packed {
        logic [REG_W-1:0] sr;
        logic [REG_W-1:0] act;
    } cfg_st_t;

    cfg_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en) begin
            if (capture)
                s_d.sr = s_q.act;
            else if (shift)
                s_d.sr = {tdi, s_q.sr[REG_W-1:1]};
            if (update)
                s_d.act = s_q.sr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign len  = s_q.act[LEN_W-1:0];
    assign flag = s_q.act[LEN_W];
    assign so   = s_q.sr[0];
endmodule

// File: rtl/jpb_burst_ctr.sv
module jpb_burst_ctr #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] cnt,
    output logic             last
);
    localparam int EXT_W = LEN_W + 1;

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear)
            s_d.cnt = '0;
        else if (step && (s_q.cnt != {LEN_W{1'b1}}))
            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic [EXT_W-1:0] idx_next;
    assign idx_next = {1'b0, s_q.cnt} + EXT_W'(1);
    assign last     = (idx_next == {1'b0, len});
    assign cnt      = s_q.cnt;
endmodule

// File: rtl/jtag_passthru_bridge.sv
module jtag_passthru_bridge
    import jpb_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic usr1_sel,
    input  logic usr2_sel,
    input  logic chain_shift,
    input  logic chain_capture,
    input  logic chain_update,
    input  logic chain_tdi,
    input  logic tgt_tdo,
    output logic chain_tdo,
    output logic tgt_tck,
    output logic tgt_tms,
    output logic tgt_tdi
);
    jpb_mode_e        mode;
    logic             mode_so;
    logic             mode_upd;
    logic [LEN_W-1:0] cfg_len;
    logic             cfg_flag;
    logic             cfg_so;
    logic [LEN_W-1:0] burst_cnt;
    logic             burst_last;
    logic             pass_en;
    logic             tms_c;
    logic             tdi_c;
    logic             tdo_c;

    jpb_mode_chain u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (usr1_sel),
        .shift   (chain_shift),
        .capture (chain_capture),
        .update  (chain_update),
        .tdi     (chain_tdi),
        .mode_q  (mode),
        .so      (mode_so),
        .upd     (mode_upd)
    );

    jpb_cfg_chain #(.LEN_W(LEN_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (usr2_sel && (mode == MODE_CFG)),
        .shift   (chain_shift),
        .capture (chain_capture),
        .update  (chain_update),
        .tdi     (chain_tdi),
        .len     (cfg_len),
        .flag    (cfg_flag),
        .so      (cfg_so)
    );

    jpb_burst_ctr #(.LEN_W(LEN_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear ((usr2_sel && chain_capture) || mode_upd),
        .step  (usr2_sel && chain_shift && (mode == MODE_XFER)),
        .len   (cfg_len),
        .cnt   (burst_cnt),
        .last  (burst_last)
    );

    always_comb begin
        pass_en = 1'b0;
        tms_c   = 1'b0;
        tdi_c   = 1'b0;
        if (usr2_sel && chain_shift) begin
            case (mode)
                MODE_TMS: begin
                    pass_en = 1'b1;
                    tms_c   = chain_tdi;
                end
                MODE_XFER: begin
                    pass_en = 1'b1;
                    tdi_c   = chain_tdi;
                    tms_c   = burst_last && cfg_flag;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        tdo_c = 1'b0;
        if (usr1_sel)
            tdo_c = mode_so;
        else if (usr2_sel) begin
            case (mode)
                MODE_CFG:            tdo_c = cfg_so;
                MODE_TMS, MODE_XFER: tdo_c = tgt_tdo;
                default:             tdo_c = 1'b0;
            endcase
        end
    end

    assign tgt_tck   = clk & pass_en;
    assign tgt_tms   = tms_c;
    assign tgt_tdi   = tdi_c;
    assign chain_tdo = tdo_c;
endmodule

// File: rtl/jpb_chk.sv
module jpb_chk
    import jpb_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             usr1_sel,
    input logic             usr2_sel,
    input logic             chain_shift,
    input logic             chain_capture,
    input logic             chain_update,
    input logic             chain_tdi,
    input jpb_mode_e        mode,
    input logic [LEN_W-1:0] cfg_len,
    input logic             cfg_flag,
    input logic [LEN_W-1:0] cnt,
    input logic             tgt_tck,
    input logic             tgt_tms,
    input logic             tgt_tdi
);
    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(usr1_sel && chain_update) |=> $stable(mode));

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(usr2_sel && chain_update && mode == MODE_CFG) |=> ($stable(cfg_len) && $stable(cfg_flag)));

    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usr2_sel && chain_capture) |=> (cnt == '0));

    // R4
    tdi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usr2_sel && chain_shift && mode == MODE_XFER) |-> (tgt_tdi == chain_tdi));

    // R5
    tms_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_XFER && tgt_tms) |-> (cfg_flag && usr2_sel && chain_shift));

    // R7
    tms_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usr2_sel && chain_shift && mode == MODE_TMS) |-> (tgt_tms == chain_tdi && !tgt_tdi));

    // R8
    tck_gate_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !(usr2_sel && chain_shift) |-> !tgt_tck);
endmodule

bind jtag_passthru_bridge jpb_chk #(.LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .usr1_sel      (usr1_sel),
    .usr2_sel      (usr2_sel),
    .chain_shift   (chain_shift),
    .chain_capture (chain_capture),
    .chain_update  (chain_update),
    .chain_tdi     (chain_tdi),
    .mode          (mode),
    .cfg_len       (cfg_len),
    .cfg_flag      (cfg_flag),
    .cnt           (burst_cnt),
    .tgt_tck       (tgt_tck),
    .tgt_tms       (tgt_tms),
    .tgt_tdi       (tgt_tdi)
);

// File: tb/tb_jtag_passthru_bridge.sv
module tb_jtag_passthru_bridge;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel1 = 0, sel2 = 0, shift = 0, capture = 0, update = 0, tdi = 0;
    logic target_tdo;
    logic chain_tdo, tgt_tck, tgt_tms, tgt_tdi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    logic [7:0] pat = 8'h5A;
    always @(negedge clk) pat <= {pat[6:0], pat[7] ^ pat[5] ^ pat[4] ^ pat[3]};
    assign target_tdo = pat[0];

    jtag_passthru_bridge dut (
        .clk(clk), .rst_n(rst_n), .usr1_sel(sel1), .usr2_sel(sel2),
        .chain_shift(shift), .chain_capture(capture), .chain_update(update),
        .chain_tdi(tdi), .tgt_tdo(target_tdo), .chain_tdo(chain_tdo),
        .tgt_tck(tgt_tck), .tgt_tms(tgt_tms), .tgt_tdi(tgt_tdi)
    );

    task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, got, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [1:0]  m_mode = 2'd3;
    logic [1:0]  m_msh  = 2'd0;
    logic [32:0] m_sh   = '0;
    logic [32:0] m_act  = '0;
    longint      m_cnt  = 0;

    always @(posedge clk) begin
        logic [1:0]  om, omsh;
        logic [32:0] osh;
        logic        e_tck, e_tms, e_tdi, e_tdo;
        if (!rst_n) begin
            m_mode = 2'd3; m_msh = 0; m_sh = 0; m_act = 0; m_cnt = 0;
        end else begin
            om = m_mode; omsh = m_msh; osh = m_sh;
            if (sel1 && capture) m_msh = om;
            else if (sel1 && shift) m_msh = {tdi, m_msh[1]};
            if (sel1 && update) m_mode = omsh;
            if (sel2 && om == 2'd0) begin
                if (capture) m_sh = m_act;
                else if (shift) m_sh = {tdi, m_sh[32:1]};
                if (update) m_act = osh;
            end
            if ((sel2 && capture) || (sel1 && update)) m_cnt = 0;
            else if (sel2 && shift && om == 2'd2 && m_cnt < 64'hFFFF_FFFF) m_cnt++;
        end
        #2;
        if (rst_n) begin
            e_tck = sel2 && shift && (m_mode == 2'd1 || m_mode == 2'd2);
            e_tdi = sel2 && shift && m_mode == 2'd2 && tdi;
            e_tms = 1'b0;
            if (sel2 && shift && m_mode == 2'd1) e_tms = tdi;
            if (sel2 && shift && m_mode == 2'd2)
                e_tms = ((m_cnt + 1) == longint'(m_act[31:0])) && m_act[32];
            e_tdo = 1'b0;
            if (sel1) e_tdo = m_msh[0];
            else if (sel2 && m_mode == 2'd0) e_tdo = m_sh[0];
            else if (sel2 && (m_mode == 2'd1 || m_mode == 2'd2)) e_tdo = target_tdo;
            check("R8", "model tgt_tck", 64'(tgt_tck), 64'(e_tck));
            check("R4", "model tgt_tdi", 64'(tgt_tdi), 64'(e_tdi));
            check(m_mode == 2'd1 ? "R7" : "R5", "model tgt_tms", 64'(tgt_tms), 64'(e_tms));
            check("R9", "model chain_tdo", 64'(chain_tdo), 64'(e_tdo));
        end
    end

    logic s_tms, s_tdi, s_tdo, s_ttdo;

    task automatic cyc(input logic a, input logic b, input logic sh, input logic cp, input logic up, input logic d);
        @(negedge clk);
        sel1 = a; sel2 = b; shift = sh; capture = cp; update = up; tdi = d;
        #1;
        s_tms = tgt_tms; s_tdi = tgt_tdi; s_tdo = chain_tdo; s_ttdo = target_tdo;
    endtask

    task automatic set_mode(input logic [1:0] code);
        cyc(1, 0, 0, 1, 0, 0);
        cyc(1, 0, 1, 0, 0, code[0]);
        cyc(1, 0, 1, 0, 0, code[1]);
        cyc(1, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic read_mode(output logic [1:0] code);
        cyc(1, 0, 0, 1, 0, 0);
        cyc(1, 0, 1, 0, 0, 0); code[0] = s_tdo;
        cyc(1, 0, 1, 0, 0, 0); code[1] = s_tdo;
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic write_cfg(input logic [31:0] len, input logic flag, output logic [32:0] rb);
        logic [32:0] v;
        v = {flag, len};
        cyc(0, 1, 0, 1, 0, 0);
        for (int i = 0; i < 33; i++) begin
            cyc(0, 1, 1, 0, 0, v[i]);
            rb[i] = s_tdo;
        end
        cyc(0, 1, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic shift_bits(input int n, input logic [15:0] data, output logic [15:0] tms_r, output logic [15:0] tdi_r);
        tms_r = '0; tdi_r = '0;
        for (int i = 0; i < n; i++) begin
            cyc(0, 1, 1, 0, 0, data[i]);
            tms_r[i] = s_tms; tdi_r[i] = s_tdi;
            check("R9", "target tdo passthrough", 64'(s_tdo), 64'(s_ttdo));
        end
    endtask

    task automatic burst(input int n, input logic [15:0] data, output logic [15:0] tms_r, output logic [15:0] tdi_r);
        cyc(0, 1, 0, 1, 0, 0);
        shift_bits(n, data, tms_r, tdi_r);
        cyc(0, 1, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic tck_probe(input string what, input logic exp);
        @(negedge clk);
        sel1 = 0; sel2 = 1; shift = 1; capture = 0; update = 0; tdi = 0;
        @(posedge clk); #2;
        check("R8", what, 64'(tgt_tck), 64'(exp));
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        logic [1:0]  code;
        logic [32:0] rb;
        logic [15:0] tr, dr;
        repeat (3) @(posedge clk);
        #2;
        check("R1", "reset tgt_tck", 64'(tgt_tck), 64'd0);
        check("R1", "reset tgt_tms", 64'(tgt_tms), 64'd0);
        check("R1", "reset tgt_tdi", 64'(tgt_tdi), 64'd0);
        check("R1", "reset chain_tdo", 64'(chain_tdo), 64'd0);
        @(negedge clk); rst_n = 1'b1;

        read_mode(code);
        check("R1", "idle mode after reset", 64'(code), 64'd3);
        tck_probe("idle mode gates tck", 1'b0);
        cyc(0, 1, 0, 0, 0, 0);
        check("R9", "idle chain_tdo low", 64'(s_tdo), 64'd0);
        cyc(0, 0, 0, 0, 0, 0);

        set_mode(2'd0);
        write_cfg(32'd5, 1'b1, rb);
        check("R1", "committed config zero after reset", 64'(rb), 64'd0);
        tck_probe("config mode gates tck", 1'b0);
        write_cfg(32'd3, 1'b1, rb);
        check("R3", "config readback", 64'(rb), 64'({1'b1, 32'd5}));

        set_mode(2'd2);
        read_mode(code);
        check("R2", "mode readback transfer", 64'(code), 64'd2);
        burst(5, 16'b10110, tr, dr);
        check("R5", "tms on third of five bits", 64'(tr[4:0]), 64'b00100);
        check("R4", "tdi forwarded", 64'(dr[4:0]), 64'b10110);
        burst(5, 16'b01101, tr, dr);
        check("R6", "capture restarts count", 64'(tr[4:0]), 64'b00100);

        cyc(0, 1, 0, 1, 0, 0);
        shift_bits(2, 16'b11, tr, dr);
        cyc(0, 0, 0, 0, 0, 0);
        set_mode(2'd2);
        shift_bits(4, 16'b0101, tr, dr);
        cyc(0, 0, 0, 0, 0, 0);
        check("R6", "mode update restarts count", 64'(tr[3:0]), 64'b0100);

        set_mode(2'd0);
        write_cfg(32'd0, 1'b1, rb);
        set_mode(2'd2);
        burst(6, 16'b111111, tr, dr);
        check("R5", "length zero never raises tms", 64'(tr[5:0]), 64'd0);

        set_mode(2'd0);
        write_cfg(32'd2, 1'b0, rb);
        set_mode(2'd2);
        burst(4, 16'b1010, tr, dr);
        check("R5", "flag zero keeps tms low", 64'(tr[3:0]), 64'd0);

        set_mode(2'd0);
        write_cfg(32'd1, 1'b1, rb);
        set_mode(2'd2);
        burst(3, 16'b000, tr, dr);
        check("R5", "length one raises first bit", 64'(tr[2:0]), 64'b001);

        set_mode(2'd1);
        read_mode(code);
        check("R2", "mode readback tms", 64'(code), 64'd1);
        tck_probe("tms mode passes tck", 1'b1);
        burst(6, 16'b101101, tr, dr);
        check("R7", "tms follows tdi", 64'(tr[5:0]), 64'b101101);
        check("R7", "tdi low in tms mode", 64'(dr[5:0]), 64'd0);

        set_mode(2'd3);
        tck_probe("idle again gates tck", 1'b0);

        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule